// File: doc/BRIEF.md
# Board Interrupt Collector and Control Register Bank

This block is the register file of a board-control logic device. It sits on a simple synchronous read/write bus addressed by byte offset and provides a set of plain 32-bit control registers. These registers drive LED data, LED control, switch settings, miscellaneous control, a software-writable "miscellaneous read" word and two card-socket control words. The LEDs, switches and sockets themselves are outside the block; only their register storage is here.

The block also gathers sixteen level-sensitive interrupt lines into one interrupt output toward the host processor. A registered copy of the lines lets the block see every change. When a line whose enable bit is set changes, the status register is overwritten with a one-hot code for that line, and the output takes that line's new level. The status register does not accumulate events. Writes to the enable and status registers pass through a fixed filter mask, so sources 8 and 12 can never be enabled.

Top module: `brd_ctl_irq_bank`

## Requirements
- R1: After a synchronous active-low reset every register reads zero, the interrupt output is low and the read data port is zero.
- R2: The plain registers store and return a full 32-bit value at byte offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4. The word at 0x90 is writable like the others.
- R3: A write to the enable register at offset 0xC0 stores the written value ANDed with 0x000FEEFF.
- R4: A bus write to the status register at offset 0xD0 stores the written value ANDed with 0x000FEEFF.
- R5: When interrupt input k changes and enable bit k is set, the status register after the next clock edge reads exactly 1<<k. The interrupt output after that edge equals the new level of input k, for both rising and falling changes.
- R6: A change on an input whose enable bit is clear leaves both the status register and the interrupt output unchanged.
- R7: When several enabled inputs change in the same cycle, the lowest-numbered one sets the one-hot status code and the output level.
- R8: A read of an unmapped offset returns zero. A write to an unmapped offset changes no register.
- R9: Read data is registered: it appears one clock after the read strobe and holds until the next read. Address bits 1:0 are ignored.
- R10: When an enabled input change and a bus write to the status register fall in the same cycle, the input capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 16 | External level interrupt lines |
| irq_out | output | 1 | Interrupt output toward the host |

## Verification
The bench builds the block with its defaults: sixteen sources, 32-bit data, an 8-bit byte offset and the 0x000FEEFF filter. With these values the filtered-out sources 8 and 12 are reachable as inputs that can never be enabled. Every mapped offset, the unused holes of the 256-byte window, and the full 16-bit source range for priority ties are also in reach.

// File: rtl/brd_ctl_pkg.sv
// Package: shared constants and the offset map of the control bank.
// Assumes word offsets (byte offset >> 2) fit in six bits.
package brd_ctl_pkg;
    localparam int NUM_PLAIN = 10;
    localparam int EN_WORD   = 'hC0 >> 2;
    localparam int ST_WORD   = 'hD0 >> 2;

    // Word offset of plain register i; the order here is only a storage order.
    function automatic int plain_word(input int i);
        case (i)
            0:       plain_word = 'h10 >> 2;
            1:       plain_word = 'h14 >> 2;
            2:       plain_word = 'h40 >> 2;
            3:       plain_word = 'h60 >> 2;
            4:       plain_word = 'h80 >> 2;
            5:       plain_word = 'h84 >> 2;
            6:       plain_word = 'h88 >> 2;
            7:       plain_word = 'h90 >> 2;
            8:       plain_word = 'hE0 >> 2;
            default: plain_word = 'hE4 >> 2;
        endcase
    endfunction
endpackage

// File: rtl/brd_plain_regs.sv
// Module: bank of plain read/write storage words at fixed word offsets.
// Assumes one write port and a combinational read select; read data is
// registered by the parent.
module brd_plain_regs #(
    parameter int DW = 32,
    parameter int WW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [WW-1:0] word,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_val,
    output logic          rd_hit
);
    import brd_ctl_pkg::*;

    logic [DW-1:0]        store [NUM_PLAIN];
    logic [NUM_PLAIN-1:0] sel;

    for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_reg
        assign sel[g] = (int'(word) == plain_word(g));
        // Purpose: hold one storage word, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)          store[g] <= '0;
            else if (wr && sel[g]) store[g] <= wdata;
        end
    end

    // Purpose: return the selected word, or zero when no word matches.
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_PLAIN; i++)
            if (sel[i]) rd_val = rd_val | store[i];
    end

    assign rd_hit = |sel;

    // A write elsewhere never disturbs this bank (R8 / R2).
    p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && rd_hit) |=> $stable(store[0]) && $stable(store[7]) && $stable(store[9]));
endmodule

// File: rtl/brd_irq_capture.sv
// Module: interrupt enable, one-hot status and output level tracking.
// Assumes NSRC <= DW. Each cycle the inputs are compared with the
// registered level vector; the lowest enabled changed line is captured.
// The capture takes precedence over a bus write to status.
module brd_irq_capture #(
    parameter int          NSRC = 16,
    parameter int          DW   = 32,
    parameter logic [31:0] MASK = 32'h000F_EEFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic            en_wr,
    input  logic            st_wr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   en_q,
    output logic [DW-1:0]   st_q,
    output logic            irq_out
);
    localparam int PW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0] lvl_q;
    logic [NSRC-1:0] hit;
    logic [PW-1:0]   pick;

    assign hit = (irq_in ^ lvl_q) & en_q[NSRC-1:0];

    // Purpose: find the lowest-numbered enabled line that changed.
    always_comb begin
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--)
            if (hit[i]) pick = PW'(i);
    end

    // Purpose: track input levels and the filtered enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            en_q  <= '0;
        end else begin
            lvl_q <= irq_in;
            if (en_wr) en_q <= wdata & DW'(MASK);
        end
    end

    // Purpose: capture an enabled change into status and the output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            irq_out <= 1'b0;
        end else if (|hit) begin
            st_q    <= DW'(1) << pick;
            irq_out <= irq_in[pick];
        end else if (st_wr) begin
            st_q    <= wdata & DW'(MASK);
        end
    end

    p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ($countones(st_q) == 1));
    p_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> (irq_out == |(st_q[NSRC-1:0] & lvl_q)));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|hit) |=> $stable(irq_out));
    p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|hit) && !st_wr) |=> $stable(st_q));
    p_filter_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> ((en_q & ~DW'(MASK)) == '0));
endmodule

// File: rtl/brd_ctl_irq_bank.sv
// Module: top of the board control bank. Decodes the byte offset (bits
// 1:0 ignored), routes writes, and registers read data one cycle after
// the read strobe. Assumes AW >= 8 so every mapped offset is reachable.
module brd_ctl_irq_bank #(
    parameter int          NSRC = 16,
    parameter int          DW   = 32,
    parameter int          AW   = 8,
    parameter logic [31:0] MASK = 32'h000F_EEFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] irq_in,
    output logic            irq_out
);
    import brd_ctl_pkg::*;
    localparam int WW = AW - 2;

    logic [WW-1:0] word;
    logic          en_sel, st_sel, pl_hit;
    logic [DW-1:0] pl_val, en_q, st_q, rd_mux;

    assign word   = bus_addr[AW-1:2];
    assign en_sel = (int'(word) == EN_WORD);
    assign st_sel = (int'(word) == ST_WORD);

    brd_plain_regs #(.DW(DW), .WW(WW)) plain_i (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .word(word),
        .wdata(bus_wdata), .rd_val(pl_val), .rd_hit(pl_hit)
    );

    brd_irq_capture #(.NSRC(NSRC), .DW(DW), .MASK(MASK)) irq_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .en_wr(bus_wr && en_sel), .st_wr(bus_wr && st_sel),
        .wdata(bus_wdata), .en_q(en_q), .st_q(st_q), .irq_out(irq_out)
    );

    // Purpose: select the addressed word, zero for an unmapped offset.
    always_comb begin
        if (en_sel)      rd_mux = en_q;
        else if (st_sel) rd_mux = st_q;
        else if (pl_hit) rd_mux = pl_val;
        else             rd_mux = '0;
    end

    // Purpose: register read data on the read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !en_sel && !st_sel && !pl_hit) |=> (bus_rdata == '0));
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/brd_ctl_irq_bank_tb_top.sv
module brd_ctl_irq_bank_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_in = '0;
    logic        irq_out;

    int n_chk = 0, n_bad = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    brd_ctl_irq_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic drive_irq(input logic [15:0] v);
        @(negedge clk); irq_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 irq_out", {31'h0, irq_out}, 32'h0);
        rd(8'h10, rv); check("R1 reg10", rv, 32'h0);
        rd(8'hC0, rv); check("R1 enable", rv, 32'h0);
        rd(8'hD0, rv); check("R1 status", rv, 32'h0);
    endtask

    task automatic t_plain();
        logic [7:0] offs [10] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80,
                                  8'h84, 8'h88, 8'h90, 8'hE0, 8'hE4};
        for (int i = 0; i < 10; i++) wr(offs[i], 32'hA5C3_0000 ^ (32'h1111_0101 * (i + 1)));
        for (int i = 0; i < 10; i++) begin
            rd(offs[i], rv);
            check("R2 plain", rv, 32'hA5C3_0000 ^ (32'h1111_0101 * (i + 1)));
        end
    endtask

    task automatic t_addr_low();
        wr(8'h13, 32'hDEAD_BEEF);
        rd(8'h11, rv); check("R9 low bits ignored", rv, 32'hDEAD_BEEF);
        @(negedge clk); check("R9 rdata holds", bus_rdata, 32'hDEAD_BEEF);
        @(negedge clk); bus_rd = 1'b1; bus_addr = 8'h14;
        check("R9 not before edge", bus_rdata, 32'hDEAD_BEEF);
        @(negedge clk); bus_rd = 1'b0;
        check("R9 one cycle later", bus_rdata, 32'hA5C3_0000 ^ 32'h2222_0202);
    endtask

    task automatic t_filters();
        wr(8'hC0, 32'hFFFF_FFFF);
        rd(8'hC0, rv); check("R3 enable filter", rv, 32'h000F_EEFF);
        wr(8'hD0, 32'hFFFF_FFFF);
        rd(8'hD0, rv); check("R4 status filter", rv, 32'h000F_EEFF);
        wr(8'hD0, 32'h0);
    endtask

    task automatic t_capture();
        drive_irq(16'h0008);
        check("R5 rise out", {31'h0, irq_out}, 32'h1);
        rd(8'hD0, rv); check("R5 rise status", rv, 32'h8);
        drive_irq(16'h0000);
        check("R5 fall out", {31'h0, irq_out}, 32'h0);
        rd(8'hD0, rv); check("R5 fall status", rv, 32'h8);
        drive_irq(16'h0001);
        rd(8'hD0, rv); check("R5 src0 status", rv, 32'h1);
        check("R5 src0 out", {31'h0, irq_out}, 32'h1);
    endtask

    task automatic t_disabled();
        drive_irq(16'h1101);
        check("R6 masked src out", {31'h0, irq_out}, 32'h1);
        rd(8'hD0, rv); check("R6 masked src status", rv, 32'h1);
        wr(8'hC0, 32'h0000_0001);
        drive_irq(16'h1121);
        rd(8'hD0, rv); check("R6 disabled status", rv, 32'h1);
        drive_irq(16'h1120);
        check("R6 enabled fall out", {31'h0, irq_out}, 32'h0);
        drive_irq(16'h1100);
        check("R6 disabled out", {31'h0, irq_out}, 32'h0);
        wr(8'hC0, 32'hFFFF_FFFF);
    endtask

    task automatic t_priority();
        drive_irq(16'h1124);
        rd(8'hD0, rv); check("R7 lowest wins status", rv, 32'h4);
        check("R7 lowest wins out", {31'h0, irq_out}, 32'h1);
        drive_irq(16'h1320);
        rd(8'hD0, rv); check("R7 falling low wins status", rv, 32'h4);
        check("R7 falling low wins out", {31'h0, irq_out}, 32'h0);
    endtask

    task automatic t_collision();
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'hD0; bus_wdata = 32'h0000_FFFF;
        irq_in = 16'h1322;
        @(negedge clk); bus_wr = 1'b0;
        rd(8'hD0, rv); check("R10 capture beats write", rv, 32'h2);
        check("R10 out", {31'h0, irq_out}, 32'h1);
    endtask

    task automatic t_unmapped();
        wr(8'h20, 32'h1234_5678);
        wr(8'hFC, 32'h8765_4321);
        rd(8'h20, rv); check("R8 unmapped read", rv, 32'h0);
        rd(8'hFC, rv); check("R8 unmapped read hi", rv, 32'h0);
        rd(8'h10, rv); check("R8 reg10 kept", rv, 32'hDEAD_BEEF);
        rd(8'hE4, rv); check("R8 regE4 kept", rv, 32'hA5C3_0000 ^ (32'h1111_0101 * 10));
        rd(8'hC0, rv); check("R8 enable kept", rv, 32'h000F_EEFF);
        rd(8'hD0, rv); check("R8 status kept", rv, 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_addr_low();
        t_filters();
        t_capture();
        t_disabled();
        t_priority();
        t_collision();
        t_unmapped();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule